// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit watches the occupancy of the transmit and receive FIFOs of an SPI controller, along with the FIFO push/pop strobes, the full/empty flags, a transaction-end pulse and a slave-command pulse. From these it builds six sticky interrupt status bits, a single combined interrupt line, level-based DMA requests for both directions, and one-cycle flush pulses for the FIFOs and the controller core. The FIFO storage and the shift engine are outside the unit.

Software reaches the unit through a flat register port. A write is one cycle with `reg_wr` high. Reads are combinational from `reg_addr`. The unit has five registers:

- **THR** at address 0 holds the TX threshold in bits [7:0] and the RX threshold in bits [15:8].
- **IEN** at address 1 holds the six enables.
- **IST** at address 2 holds the six status bits. Writing 1 to a bit clears it.
- **CTL** at address 3 holds the DMA enables in bits 0 and 1, a TX flush in bit 2, an RX flush in bit 3 and a core reset in bit 4. Bits 2 to 4 clear themselves.
- **LVL** at address 4 is read-only and shows the TX level in bits [7:0] and the RX level in bits [15:8].

Any other address reads as zero.

The flush and reset pulses come from a small sequencer with five states:

- **RS_IDLE** drives no pulse.
- **RS_FLUSH_TX** drives the TX flush.
- **RS_FLUSH_RX** drives the RX flush.
- **RS_FLUSH_BOTH** drives both FIFO flushes.
- **RS_CORE** drives all three pulses and returns every register to its reset value.

In every state, the next state is chosen only by a write to CTL in the current cycle:

- **go_core**: bit 4 is set.
- **go_both**: bits 3 and 2 are set.
- **go_rx**: only bit 3 is set.
- **go_tx**: only bit 2 is set.
- **go_idle**: anything else.

Every non-idle state therefore lasts one cycle unless it is requested again.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset, IST, IEN and CTL read 0 and THR reads 0x0100 (TX threshold 0, RX threshold 1). `irq`, both DMA requests and all pulse outputs are low.
- R2: Status bit 0 sets on `rx_push` while `rx_full` is high. Bit 1 sets on `tx_pop` while `tx_empty` and `data_phase` are both high. Bit 2 sets in every cycle where RX level >= RX threshold. Bit 3 sets in every cycle where TX level <= TX threshold. Bit 4 sets on `xfer_end`. Bit 5 sets on `slv_cmd`.
- R3: Writing IST clears each status bit whose write-data bit is 1; bits written 0 keep their value.
- R4: When a set condition and a clear by a write happen in the same cycle, the status bit ends up set.
- R5: `irq` is high exactly when some status bit and its IEN bit, at the same position, are both 1.
- R6: A threshold field written above the FIFO depth (8 by default) is stored as the depth; THR reads back the stored values.
- R7: `tx_dma_req` is high while CTL bit 0 is set and TX level <= TX threshold. `rx_dma_req` is high while CTL bit 1 is set and RX level >= RX threshold.
- R8: A CTL write with bit 2 and/or bit 3 set gives a one-cycle `tx_fifo_clr` and/or `rx_fifo_clr` pulse in the following cycle. CTL bits 2 to 4 read as the pulse outputs.
- R9: A CTL write with bit 4 set gives, in the following cycle, one cycle with all three pulses high. At the end of that cycle IST, IEN, THR and the DMA enables return to their reset values; a set condition or a register write in that cycle has no effect.
- R10: LVL reads the current TX level in bits [7:0] and the current RX level in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_level | input | 4 | TX FIFO valid entries |
| rx_level | input | 4 | RX FIFO valid entries |
| tx_pop | input | 1 | TX FIFO pop strobe |
| tx_empty | input | 1 | TX FIFO empty |
| rx_push | input | 1 | RX FIFO push strobe |
| rx_full | input | 1 | RX FIFO full |
| data_phase | input | 1 | Shift engine is in a data phase |
| xfer_end | input | 1 | Transaction-end pulse |
| slv_cmd | input | 1 | Slave command received pulse |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_fifo_clr | output | 1 | TX FIFO flush pulse |
| rx_fifo_clr | output | 1 | RX FIFO flush pulse |
| core_clr | output | 1 | Controller core reset pulse |

## Verification
A status bit stuck or lost inside the unit shows up on `irq` one cycle after the event, once its enable is on. The same bit is visible on an IST read in that cycle. A wrong threshold or DMA enable shows on the DMA request lines in the same cycle as the level changes. A sequencer that lands in the wrong state drives a wrong flush pulse the cycle after the CTL write. A missed core reset leaves stale IEN or THR contents visible on the very next read. The bench therefore compares every output and the read port on every clock, so each of these faults is caught within one cycle.

// File: rtl/spi_fsi_pkg.sv
package spi_fsi_pkg;
    localparam int ADDR_W = 3;
    localparam int FLD_W  = 8;
    localparam int N_SRC  = 6;

    localparam int SRC_RX_OVF = 0;
    localparam int SRC_TX_UDF = 1;
    localparam int SRC_RX_THR = 2;
    localparam int SRC_TX_THR = 3;
    localparam int SRC_END    = 4;
    localparam int SRC_SCMD   = 5;

    localparam logic [ADDR_W-1:0] A_THR = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN = 3'd1;
    localparam logic [ADDR_W-1:0] A_IST = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_LVL = 3'd4;

    localparam int C_TXDMA   = 0;
    localparam int C_RXDMA   = 1;
    localparam int C_TXFLUSH = 2;
    localparam int C_RXFLUSH = 3;
    localparam int C_CORE    = 4;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_FLUSH_TX,
        RS_FLUSH_RX,
        RS_FLUSH_BOTH,
        RS_CORE
    } rst_state_e;
endpackage

// File: rtl/spi_rst_seq.sv
module spi_rst_seq
    import spi_fsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic flush_tx_req,
    input  logic flush_rx_req,
    input  logic core_req,
    output logic tx_clr,
    output logic rx_clr,
    output logic core_clr
);
    rst_state_e state_q, state_d;

    // Next state depends only on this cycle's CTL write.
    always_comb begin
        state_d = RS_IDLE;
        if (ctl_wr) begin
            unique casez ({core_req, flush_rx_req, flush_tx_req})
                3'b1??:  state_d = RS_CORE;
                3'b011:  state_d = RS_FLUSH_BOTH;
                3'b010:  state_d = RS_FLUSH_RX;
                3'b001:  state_d = RS_FLUSH_TX;
                default: state_d = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_clr   = 1'b0;
        rx_clr   = 1'b0;
        core_clr = 1'b0;
        unique case (state_q)
            RS_IDLE:       ;
            RS_FLUSH_TX:   tx_clr = 1'b1;
            RS_FLUSH_RX:   rx_clr = 1'b1;
            RS_FLUSH_BOTH: begin tx_clr = 1'b1; rx_clr = 1'b1; end
            RS_CORE:       begin tx_clr = 1'b1; rx_clr = 1'b1; core_clr = 1'b1; end
            default:       ;
        endcase
    end
endmodule

// File: rtl/spi_thr_detect.sv
module spi_thr_detect #(
    parameter int LVL_W    = 4,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr,
    output logic             hit
);
    generate
        if (AT_LEAST) begin : g_ge
            assign hit = (level >= thr);
        end else begin : g_le
            assign hit = (level <= thr);
        end
    endgenerate
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [N-1:0] set,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] stat
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stat[g] <= 1'b0;
            else if (wipe)   stat[g] <= 1'b0;
            else if (set[g]) stat[g] <= 1'b1;
            else if (w1c[g]) stat[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fsi_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_pop,
    input  logic              tx_empty,
    input  logic              rx_push,
    input  logic              rx_full,
    input  logic              data_phase,
    input  logic              xfer_end,
    input  logic              slv_cmd,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tx_fifo_clr,
    output logic              rx_fifo_clr,
    output logic              core_clr
);
    localparam logic [LVL_W-1:0] TX_THR_RST = '0;
    localparam logic [LVL_W-1:0] RX_THR_RST = LVL_W'(1);

    logic [N_SRC-1:0] ien_q;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] w1c_vec;
    logic [LVL_W-1:0] txthr_q, rxthr_q;
    logic [1:0]       dma_en_q;
    logic             tx_hit, rx_hit;
    logic             wr_thr, wr_ien, wr_ist, wr_ctl;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:2*FLD_W];

    assign wr_thr = reg_wr && (reg_addr == A_THR);
    assign wr_ien = reg_wr && (reg_addr == A_IEN);
    assign wr_ist = reg_wr && (reg_addr == A_IST);
    assign wr_ctl = reg_wr && (reg_addr == A_CTL);

    function automatic logic [LVL_W-1:0] sat_thr(input logic [FLD_W-1:0] v);
        if (v > FLD_W'(DEPTH)) return LVL_W'(DEPTH);
        return v[LVL_W-1:0];
    endfunction

    spi_rst_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (wr_ctl),
        .flush_tx_req (reg_wdata[C_TXFLUSH]),
        .flush_rx_req (reg_wdata[C_RXFLUSH]),
        .core_req     (reg_wdata[C_CORE]),
        .tx_clr       (tx_fifo_clr),
        .rx_clr       (rx_fifo_clr),
        .core_clr     (core_clr)
    );

    spi_thr_detect #(.LVL_W(LVL_W), .AT_LEAST(1'b0)) u_tx_thr (
        .level (tx_level),
        .thr   (txthr_q),
        .hit   (tx_hit)
    );

    spi_thr_detect #(.LVL_W(LVL_W), .AT_LEAST(1'b1)) u_rx_thr (
        .level (rx_level),
        .thr   (rxthr_q),
        .hit   (rx_hit)
    );

    // Configuration registers; core reset pulse dominates writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q    <= '0;
            txthr_q  <= TX_THR_RST;
            rxthr_q  <= RX_THR_RST;
            dma_en_q <= '0;
        end else if (core_clr) begin
            ien_q    <= '0;
            txthr_q  <= TX_THR_RST;
            rxthr_q  <= RX_THR_RST;
            dma_en_q <= '0;
        end else begin
            if (wr_ien) ien_q <= reg_wdata[N_SRC-1:0];
            if (wr_thr) begin
                txthr_q <= sat_thr(reg_wdata[FLD_W-1:0]);
                rxthr_q <= sat_thr(reg_wdata[2*FLD_W-1:FLD_W]);
            end
            if (wr_ctl) dma_en_q <= {reg_wdata[C_RXDMA], reg_wdata[C_TXDMA]};
        end
    end

    always_comb begin
        set_vec             = '0;
        set_vec[SRC_RX_OVF] = rx_push && rx_full;
        set_vec[SRC_TX_UDF] = tx_pop && tx_empty && data_phase;
        set_vec[SRC_RX_THR] = rx_hit;
        set_vec[SRC_TX_THR] = tx_hit;
        set_vec[SRC_END]    = xfer_end;
        set_vec[SRC_SCMD]   = slv_cmd;
    end

    assign w1c_vec = wr_ist ? reg_wdata[N_SRC-1:0] : '0;

    spi_irq_status #(.N(N_SRC)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (core_clr),
        .set   (set_vec),
        .w1c   (w1c_vec),
        .stat  (stat_q)
    );

    assign irq        = |(stat_q & ien_q);
    assign tx_dma_req = dma_en_q[0] && tx_hit;
    assign rx_dma_req = dma_en_q[1] && rx_hit;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_THR: begin
                reg_rdata[FLD_W-1:0]       = FLD_W'(txthr_q);
                reg_rdata[2*FLD_W-1:FLD_W] = FLD_W'(rxthr_q);
            end
            A_IEN: reg_rdata[N_SRC-1:0] = ien_q;
            A_IST: reg_rdata[N_SRC-1:0] = stat_q;
            A_CTL: begin
                reg_rdata[C_TXDMA]   = dma_en_q[0];
                reg_rdata[C_RXDMA]   = dma_en_q[1];
                reg_rdata[C_TXFLUSH] = tx_fifo_clr;
                reg_rdata[C_RXFLUSH] = rx_fifo_clr;
                reg_rdata[C_CORE]    = core_clr;
            end
            A_LVL: begin
                reg_rdata[FLD_W-1:0]       = FLD_W'(tx_level);
                reg_rdata[2*FLD_W-1:FLD_W] = FLD_W'(rx_level);
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fsi_checker.sv
module spi_fsi_checker
    import spi_fsi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              xfer_end,
    input logic              irq,
    input logic              tx_dma_req,
    input logic              rx_dma_req,
    input logic              tx_fifo_clr,
    input logic              rx_fifo_clr,
    input logic              core_clr,
    input logic [N_SRC-1:0]  stat
);
    p_end_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end && !core_clr |=> stat[SRC_END]);

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_IST && reg_wdata[SRC_END] && !xfer_end && !core_clr
        |=> !stat[SRC_END]);

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_IST && reg_wdata[SRC_END] && xfer_end && !core_clr
        |=> stat[SRC_END]);

    p_ien_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_IEN && reg_wdata[N_SRC-1:0] == '0 |=> !irq);

    p_txdma_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_CTL && !reg_wdata[C_TXDMA] |=> !tx_dma_req);

    p_rxdma_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_CTL && !reg_wdata[C_RXDMA] |=> !rx_dma_req);

    p_flush_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_CTL && reg_wdata[C_TXFLUSH] |=> tx_fifo_clr);

    p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |-> $past(reg_wr && reg_addr == A_CTL &&
                              (reg_wdata[C_RXFLUSH] || reg_wdata[C_CORE])));

    p_core_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_clr |-> tx_fifo_clr && rx_fifo_clr);

    p_core_wipes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_clr |=> stat == '0);
endmodule

bind spi_fifo_irq_unit spi_fsi_checker #(.DATA_W(DATA_W)) u_fsi_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .xfer_end    (xfer_end),
    .irq         (irq),
    .tx_dma_req  (tx_dma_req),
    .rx_dma_req  (rx_dma_req),
    .tx_fifo_clr (tx_fifo_clr),
    .rx_fifo_clr (rx_fifo_clr),
    .core_clr    (core_clr),
    .stat        (stat_q)
);

// File: tb/spi_fifo_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_bench;
    localparam int DEPTH = 8;
    localparam int LVL_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [LVL_W-1:0] tx_level = 4'd4, rx_level = 4'd0;
    logic tx_pop = 0, tx_empty = 0, rx_push = 0, rx_full = 0;
    logic data_phase = 0, xfer_end = 0, slv_cmd = 0;
    logic irq, tx_dma_req, rx_dma_req, tx_fifo_clr, rx_fifo_clr, core_clr;

    int n_chk = 0, n_err = 0, cyc = 0;

    always #5 clk = ~clk;

    spi_fifo_irq_unit u_spi_fifo_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level), .tx_pop(tx_pop),
        .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
        .data_phase(data_phase), .xfer_end(xfer_end), .slv_cmd(slv_cmd),
        .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr), .core_clr(core_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    logic [5:0] m_stat, m_en;
    logic [1:0] m_dma;
    int m_txthr, m_rxthr, m_pend;   // m_pend: 0 none, 1 tx, 2 rx, 3 both, 4 core

    function automatic int sat(input int v);
        return (v > DEPTH) ? DEPTH : v;
    endfunction

    always @(posedge clk) begin
        logic [5:0] s, c;
        int np;
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_dma = 0; m_txthr = 0; m_rxthr = 1; m_pend = 0;
        end else begin
            s = 0;
            s[0] = rx_push && rx_full;
            s[1] = tx_pop && tx_empty && data_phase;
            s[2] = (int'(rx_level) >= m_rxthr);
            s[3] = (int'(tx_level) <= m_txthr);
            s[4] = xfer_end;
            s[5] = slv_cmd;
            c = (reg_wr && reg_addr == 3'd2) ? reg_wdata[5:0] : 6'd0;
            np = 0;
            if (reg_wr && reg_addr == 3'd3) begin
                if (reg_wdata[4]) np = 4;
                else np = {30'd0, reg_wdata[3], reg_wdata[2]};
            end
            if (m_pend == 4) begin
                m_stat = 0; m_en = 0; m_dma = 0; m_txthr = 0; m_rxthr = 1;
            end else begin
                m_stat = (m_stat & ~c) | s;   // R4: set beats clear
                if (reg_wr && reg_addr == 3'd1) m_en = reg_wdata[5:0];
                if (reg_wr && reg_addr == 3'd0) begin
                    m_txthr = sat(int'(reg_wdata[7:0]));
                    m_rxthr = sat(int'(reg_wdata[15:8]));
                end
                if (reg_wr && reg_addr == 3'd3) m_dma = reg_wdata[1:0];
            end
            m_pend = np;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] r = 0;
        case (a)
            3'd0: r = {16'd0, 8'(m_rxthr), 8'(m_txthr)};
            3'd1: r = {26'd0, m_en};
            3'd2: r = {26'd0, m_stat};
            3'd3: r = {27'd0, m_pend == 4, m_pend == 2 || m_pend >= 3,
                       m_pend == 1 || m_pend == 3 || m_pend == 4, m_dma};
            3'd4: r = {16'd0, 4'd0, rx_level, 4'd0, tx_level};
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R6 THR read";
            3'd1: return "R5 IEN read";
            3'd2: return "R2/R3 IST read";
            3'd3: return "R8 CTL read";
            3'd4: return "R10 LVL read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
            chk("R7 tx_dma_req", {31'd0, tx_dma_req},
                {31'd0, m_dma[0] && (int'(tx_level) <= m_txthr)});
            chk("R7 rx_dma_req", {31'd0, rx_dma_req},
                {31'd0, m_dma[1] && (int'(rx_level) >= m_rxthr)});
            chk("R8 tx_fifo_clr", {31'd0, tx_fifo_clr},
                {31'd0, m_pend == 1 || m_pend == 3 || m_pend == 4});
            chk("R8 rx_fifo_clr", {31'd0, rx_fifo_clr}, {31'd0, m_pend == 2 || m_pend >= 3});
            chk("R9 core_clr", {31'd0, core_clr}, {31'd0, m_pend == 4});
            chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rdchk(input logic [2:0] a, input logic [31:0] e, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, e);
        #1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rdchk(3'd2, 32'h0, "R1 IST");
        rdchk(3'd1, 32'h0, "R1 IEN");
        rdchk(3'd0, 32'h0100, "R1 THR");
        rdchk(3'd3, 32'h0, "R1 CTL");
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 dma", {30'd0, tx_dma_req, rx_dma_req}, 32'd0);

        wr(3'd1, 32'h3F);
        reg_addr = 3'd2;
        // R2 event sources
        xfer_end = 1; tick(1); xfer_end = 0; tick(1);
        slv_cmd = 1; tick(1); slv_cmd = 0; tick(1);
        rx_push = 1; tick(1); rx_full = 1; tick(1); rx_push = 0; rx_full = 0;
        tx_pop = 1; tx_empty = 1; tick(1); data_phase = 1; tick(1);
        tx_pop = 0; tx_empty = 0; data_phase = 0; tick(1);
        // R3 clear all, then write 0
        wr(3'd2, 32'h3F); tick(2);
        wr(3'd2, 32'h0); tick(1);
        // R2/R6 thresholds
        wr(3'd0, 32'h0302); reg_addr = 3'd2;
        rx_level = 2; tick(1); rx_level = 3; tick(1); rx_level = 5; tick(1);
        tx_level = 3; tick(1); tx_level = 2; tick(1); tx_level = 0; tick(1);
        tx_level = 4; rx_level = 0; tick(1);
        wr(3'd0, 32'hFF09);
        rdchk(3'd0, 32'h0808, "R6 saturate both");
        wr(3'd0, 32'h0709);
        rdchk(3'd0, 32'h0708, "R6 saturate tx");
        wr(3'd0, 32'h0300);
        wr(3'd2, 32'h3F); tick(1);
        // R4 set and clear in the same cycle
        xfer_end = 1; wr(3'd2, 32'h10); xfer_end = 0;
        reg_addr = 3'd2; @(negedge clk);
        chk("R4 set wins", {31'd0, reg_rdata[4]}, 32'd1); #1;
        wr(3'd2, 32'h10);
        reg_addr = 3'd2; @(negedge clk);
        chk("R3 w1c", {31'd0, reg_rdata[4]}, 32'd0); #1;
        xfer_end = 1; tick(1); xfer_end = 0;
        wr(3'd2, 32'h0);
        reg_addr = 3'd2; @(negedge clk);
        chk("R3 write zero keeps", {31'd0, reg_rdata[4]}, 32'd1); #1;
        wr(3'd1, 32'h00); tick(1);
        wr(3'd1, 32'h10); tick(1);
        // R7 DMA gating
        wr(3'd3, 32'h1);
        tx_level = 0; tick(1); tx_level = 1; tick(1); tx_level = 4; rx_level = 3; tick(1);
        wr(3'd3, 32'h2); rx_level = 2; tick(1); rx_level = 6; tick(1);
        wr(3'd3, 32'h3); tx_level = 0; tick(1);
        wr(3'd3, 32'h0); tick(1);
        tx_level = 4; rx_level = 0;
        // R8 flush pulses
        reg_addr = 3'd3;
        wr(3'd3, 32'h4); tick(1);
        wr(3'd3, 32'h8); tick(1);
        wr(3'd3, 32'hC); tick(2);
        // R9 core reset
        wr(3'd1, 32'h3F); wr(3'd0, 32'h0505);
        xfer_end = 1; tick(1); xfer_end = 0;
        wr(3'd3, 32'h13);
        tick(1);
        rdchk(3'd1, 32'h0, "R9 IEN");
        rdchk(3'd0, 32'h0100, "R9 THR");
        rdchk(3'd2, 32'h0, "R9 IST");
        rdchk(3'd3, 32'h0, "R9 CTL");
        // R10 levels
        tx_level = 7; rx_level = 8;
        rdchk(3'd4, 32'h0807, "R10 levels");
        tx_level = 0; rx_level = 1;
        rdchk(3'd4, 32'h0100, "R10 levels");
        rdchk(3'd6, 32'h0, "R10 unmapped");
        tick(3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule